// File: doc/BRIEF.md
# Index-Driven Block Absorber

This block folds one 128-bit message block and a 12-bit domain tag into a 320-bit permutation state. The state is held as five 64-bit words, and each word is stored bit-interleaved: an even half holds the word's even-numbered bits and an odd half holds its odd-numbered bits. The message is not XORed in directly. Instead, the block and the tag are treated as one 140-bit string, and that string is cut into fourteen 10-bit groups. Each group is five 2-bit indices, and each index picks one of four 32-bit words from a small key table. The picked word is XORed into the even half of one state word. Between groups, a full permutation round runs with a fixed constant.

After the last group, the block runs the requested number of permutation rounds. On each of these rounds it also updates a 128-bit output accumulator. The accumulator is built from halves of the first four state words.

A caller loads the state, the key table, the message, the tag and the round count, then pulses start. The block samples every operand on that edge. One group is processed per clock, then one round per clock. The block pulses done when the last round has been written. The final state and the accumulator stay on the outputs until the next accepted start.

Top module: `dg_mix_absorber`

## Requirements
- R1: After reset, done_o is low and state_o and racc_o are all zeros.
- R2: A start_i seen while the block is idle samples data_i, dsep_i, rounds_i, xtab_i and state_i on that edge. Changing those inputs afterwards has no effect on the result.
- R3: The mix string has data_i in bits 0..127 and dsep_i in bits 128..139. It is consumed as fourteen 10-bit groups, starting with bits 0..9 and ending with bits 130..139.
- R4: The state port holds ten 32-bit halves. Half 2i, at bits [64i+31:64i], is the even half of word ci. Half 2i+1 is its odd half. The key table holds word j at xtab_i[32j+31:32j]. Within a group, bits [2i+1:2i] (i = 0..4) give the index j whose word is XORed into the even half of ci.
- R5: After every group except the last, one round runs with constant 0xf0. No round runs after the last group. The accumulator is not changed during mixing, so racc_o keeps its previous value.
- R6: A round does three things in order. First, it XORs the constant into bits [7:0] of the even half of c2. Second, it applies the bitwise 5-bit S-box: x0^=x4, x4^=x3, x2^=x1, t_i=~x_i & x_(i+1 mod 5), x_i^=t_(i+1 mod 5), then x1^=x0, x3^=x2, x0^=x4, x2=~x2. Third, it applies ci ^= rotr(ci,a) ^ rotr(ci,b) on the 64-bit words, with (a,b) equal to (19,28), (61,38), (1,6), (10,17) and (7,40) for c0..c4.
- R7: The final phase runs rounds_i rounds, with rounds_i in 1..12. Round k, counting from 0, uses the constant 0xf0 - 0x0f*k.
- R8: The accumulator is cleared when mixing ends. After each final-phase round it takes, on the new state: word0 ^= even(c0)^odd(c2), word1 ^= odd(c0)^even(c3), word2 ^= even(c1)^odd(c3), word3 ^= odd(c1)^even(c2). Word w sits at racc_o[32w+31:32w].
- R9: done_o goes high in the cycle after the (15+N)-th rising edge, counting from the edge before the one that samples start, where N is the sampled round count.
- R10: A start_i seen while the block is busy is ignored.
- R11: done_o is a one-cycle pulse. state_o and racc_o hold their values while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an absorb when idle |
| data_i | input | 128 | Message block |
| dsep_i | input | 12 | Domain tag |
| rounds_i | input | 4 | Final-phase round count, 1..12 |
| xtab_i | input | 128 | Four 32-bit key table words |
| state_i | input | 320 | Initial interleaved state |
| state_o | output | 320 | Current interleaved state |
| racc_o | output | 128 | Round accumulator |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the round count given with an accepted start lies between 1 and 12. A count of zero has no defined meaning here, because the final phase always runs at least one round. The bench draws every count from that range and covers both ends, 1 and 12. It raises start_i again mid-operation only to check that the block ignores it; all other starts are given while the block is idle. Tags of all zeros and all ones are exercised alongside random ones.

// File: rtl/dg_mix_pkg.sv
package dg_mix_pkg;
  localparam int unsigned HALF_W     = 32;
  localparam int unsigned NUM_WORDS  = 5;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned NUM_X      = 1 << SEL_W;
  localparam int unsigned CHUNK_W    = NUM_WORDS * SEL_W;
  localparam int unsigned DATA_W     = 128;
  localparam int unsigned DSEP_W     = 12;
  localparam int unsigned MIX_W      = DATA_W + DSEP_W;
  localparam int unsigned NUM_CHUNKS = (MIX_W + CHUNK_W - 1) / CHUNK_W;
  localparam int unsigned CHK_W      = $clog2(NUM_CHUNKS);
  localparam int unsigned XTAB_W     = HALF_W * NUM_X;
  localparam int unsigned WORD_W     = 2 * HALF_W;
  localparam int unsigned STATE_W    = WORD_W * NUM_WORDS;
  localparam int unsigned RACC_W     = 4 * HALF_W;
  localparam int unsigned RND_W      = 4;
  localparam int unsigned MAX_ROUNDS = 12;
  localparam int unsigned RC_W       = 8;
  localparam logic [RC_W-1:0] MIX_RC  = 8'hf0;
  localparam logic [RC_W-1:0] RC_BASE = 8'hf0;
  localparam logic [RC_W-1:0] RC_STEP = 8'h0f;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [NUM_WORDS-1:0] state_t;

  typedef enum logic [1:0] {PH_IDLE, PH_MIX, PH_RUN} phase_e;

  function automatic half_t ev(word_t w);
    return w[HALF_W-1:0];
  endfunction

  function automatic half_t od(word_t w);
    return w[WORD_W-1:HALF_W];
  endfunction

  function automatic half_t rotr_h(half_t x, int unsigned s);
    int unsigned m;
    m = s % HALF_W;
    if (m == 0) return x;
    return (x >> m) | (x << (HALF_W - m));
  endfunction

  // 64-bit rotate on an interleaved word
  function automatic word_t rotr_il(word_t w, int unsigned n);
    int unsigned k;
    k = n / 2;
    if (n % 2 == 0) return {rotr_h(od(w), k), rotr_h(ev(w), k)};
    return {rotr_h(ev(w), k + 1), rotr_h(od(w), k)};
  endfunction

  function automatic int unsigned rot_a(int unsigned i);
    case (i)
      0: return 19;
      1: return 61;
      2: return 1;
      3: return 10;
      default: return 7;
    endcase
  endfunction

  function automatic int unsigned rot_b(int unsigned i);
    case (i)
      0: return 28;
      1: return 38;
      2: return 6;
      3: return 17;
      default: return 40;
    endcase
  endfunction
endpackage

// File: rtl/dg_mix_chunk.sv
module dg_mix_chunk
  import dg_mix_pkg::*;
(
  input  state_t             s_i,
  input  logic [CHUNK_W-1:0] chunk_i,
  input  logic [XTAB_W-1:0]  xtab_i,
  output state_t             s_o
);
  half_t xw [NUM_X];

  for (genvar j = 0; j < NUM_X; j++) begin : g_xw
    assign xw[j] = xtab_i[j*HALF_W +: HALF_W];
  end

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic [SEL_W-1:0] sel;
    assign sel    = chunk_i[i*SEL_W +: SEL_W];
    assign s_o[i] = {od(s_i[i]), ev(s_i[i]) ^ xw[sel]};
  end
endmodule

// File: rtl/dg_round.sv
module dg_round
  import dg_mix_pkg::*;
(
  input  state_t          s_i,
  input  logic [RC_W-1:0] rc_i,
  output state_t          s_o
);
  state_t sb;

  always_comb begin
    word_t x0, x1, x2, x3, x4;
    word_t t0, t1, t2, t3, t4;
    x0 = s_i[0];
    x1 = s_i[1];
    x2 = s_i[2] ^ WORD_W'(rc_i);
    x3 = s_i[3];
    x4 = s_i[4];
    x0 = x0 ^ x4;
    x4 = x4 ^ x3;
    x2 = x2 ^ x1;
    t0 = ~x0 & x1;
    t1 = ~x1 & x2;
    t2 = ~x2 & x3;
    t3 = ~x3 & x4;
    t4 = ~x4 & x0;
    x0 = x0 ^ t1;
    x1 = x1 ^ t2;
    x2 = x2 ^ t3;
    x3 = x3 ^ t4;
    x4 = x4 ^ t0;
    x1 = x1 ^ x0;
    x3 = x3 ^ x2;
    x0 = x0 ^ x4;
    x2 = ~x2;
    sb = {x4, x3, x2, x1, x0};
  end

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_lin
    assign s_o[i] = sb[i] ^ rotr_il(sb[i], rot_a(i)) ^ rotr_il(sb[i], rot_b(i));
  end
endmodule

// File: rtl/dg_racc_fold.sv
module dg_racc_fold
  import dg_mix_pkg::*;
(
  input  state_t            s_i,
  input  logic [RACC_W-1:0] r_i,
  output logic [RACC_W-1:0] r_o
);
  assign r_o = r_i ^ {od(s_i[1]) ^ ev(s_i[2]),
                      ev(s_i[1]) ^ od(s_i[3]),
                      od(s_i[0]) ^ ev(s_i[3]),
                      ev(s_i[0]) ^ od(s_i[2])};
endmodule

// File: rtl/dg_mix_absorber.sv
module dg_mix_absorber
  import dg_mix_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [DSEP_W-1:0]   dsep_i,
  input  logic [RND_W-1:0]    rounds_i,
  input  logic [XTAB_W-1:0]   xtab_i,
  input  logic [STATE_W-1:0]  state_i,
  output logic [STATE_W-1:0]  state_o,
  output logic [RACC_W-1:0]   racc_o,
  output logic                done_o
);
  localparam logic [CHK_W-1:0] LAST_CHUNK = CHK_W'(NUM_CHUNKS - 1);

  phase_e              phase_q;
  logic [CHK_W-1:0]    chunk_q;
  logic [RND_W-1:0]    rcnt_q, rounds_q;
  logic [MIX_W-1:0]    mix_q;
  logic [XTAB_W-1:0]   xtab_q;
  state_t              st_q;
  logic [RACC_W-1:0]   racc_q;
  logic                done_q;

  state_t              mixed, rnd_in, rnd_out;
  logic [RC_W-1:0]     rc_seq, rc_sel;
  logic [RACC_W-1:0]   racc_nx;

  dg_mix_chunk i_chunk (
    .s_i    (st_q),
    .chunk_i(mix_q[CHUNK_W-1:0]),
    .xtab_i (xtab_q),
    .s_o    (mixed)
  );

  // one round engine shared by both phases
  assign rc_seq = RC_BASE - RC_W'(RC_STEP * RC_W'(rcnt_q));
  assign rc_sel = (phase_q == PH_MIX) ? MIX_RC : rc_seq;
  assign rnd_in = (phase_q == PH_MIX) ? mixed : st_q;

  dg_round i_round (
    .s_i (rnd_in),
    .rc_i(rc_sel),
    .s_o (rnd_out)
  );

  dg_racc_fold i_fold (
    .s_i(rnd_out),
    .r_i(racc_q),
    .r_o(racc_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      chunk_q  <= '0;
      rcnt_q   <= '0;
      rounds_q <= '0;
      mix_q    <= '0;
      xtab_q   <= '0;
      st_q     <= '0;
      racc_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            mix_q    <= {dsep_i, data_i};
            xtab_q   <= xtab_i;
            st_q     <= state_i;
            rounds_q <= rounds_i;
            chunk_q  <= '0;
            phase_q  <= PH_MIX;
          end
        end
        PH_MIX: begin
          mix_q   <= mix_q >> CHUNK_W;
          chunk_q <= chunk_q + 1'b1;
          if (chunk_q == LAST_CHUNK) begin
            st_q    <= mixed;
            racc_q  <= '0;
            rcnt_q  <= '0;
            phase_q <= PH_RUN;
          end else begin
            st_q <= rnd_out;
          end
        end
        PH_RUN: begin
          st_q   <= rnd_out;
          racc_q <= racc_nx;
          rcnt_q <= rcnt_q + 1'b1;
          if (rcnt_q == rounds_q - RND_W'(1)) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign racc_o  = racc_q;
  assign done_o  = done_q;

  AST_ROUNDS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && phase_q == PH_IDLE) |-> (rounds_i >= RND_W'(1) && rounds_i <= RND_W'(MAX_ROUNDS))); // R7
  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN) |-> (rcnt_q < rounds_q)); // R7
  AST_CHUNK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_MIX) |-> (chunk_q <= LAST_CHUNK)); // R3
  AST_MIX_RACC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_MIX && chunk_q != LAST_CHUNK) |=> $stable(racc_o)); // R5
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |=> ($stable(xtab_q) && $stable(rounds_q))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_FROM_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(phase_q) == PH_RUN)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !start_i) |=> ($stable(state_o) && $stable(racc_o))); // R11
endmodule

// File: tb/test_dg_mix_absorber.sv
module test_dg_mix_absorber;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] data_i = '0;
  logic [11:0]  dsep_i = '0;
  logic [3:0]   rounds_i = 4'd1;
  logic [127:0] xtab_i = '0;
  logic [319:0] state_i = '0;
  logic [319:0] state_o;
  logic [127:0] racc_o;
  logic         done_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    logic [319:0] st;
    logic [127:0] r;
    int           lat;
    int           t0;
  } exp_t;
  exp_t sb_q[$];

  logic [127:0] last_r = '0;
  logic [319:0] hold_st;
  logic [127:0] hold_r;
  bit           chk_hold = 0;

  dg_mix_absorber i_dg_mix_absorber (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start_i),
    .data_i  (data_i),
    .dsep_i  (dsep_i),
    .rounds_i(rounds_i),
    .xtab_i  (xtab_i),
    .state_i (state_i),
    .state_o (state_o),
    .racc_o  (racc_o),
    .done_o  (done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [319:0] act, input logic [319:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // reference model on de-interleaved 64-bit words
  function automatic logic [63:0] il2w(logic [31:0] e, logic [31:0] o);
    logic [63:0] v;
    for (int m = 0; m < 32; m++) begin
      v[2*m]   = e[m];
      v[2*m+1] = o[m];
    end
    return v;
  endfunction

  function automatic logic [31:0] w_ev(logic [63:0] v);
    logic [31:0] e;
    for (int m = 0; m < 32; m++) e[m] = v[2*m];
    return e;
  endfunction

  function automatic logic [31:0] w_od(logic [63:0] v);
    logic [31:0] o;
    for (int m = 0; m < 32; m++) o[m] = v[2*m+1];
    return o;
  endfunction

  function automatic logic [63:0] rr(logic [63:0] v, int n);
    return (v >> n) | (v << (64 - n));
  endfunction

  function automatic logic [4:0][63:0] ref_round(logic [4:0][63:0] s, logic [7:0] rc);
    logic [63:0] a, b, c, d, e, t0, t1, t2, t3, t4;
    a = s[0]; b = s[1]; c = s[2] ^ il2w({24'd0, rc}, 32'd0); d = s[3]; e = s[4];
    a ^= e; e ^= d; c ^= b;
    t0 = ~a & b; t1 = ~b & c; t2 = ~c & d; t3 = ~d & e; t4 = ~e & a;
    a ^= t1; b ^= t2; c ^= t3; d ^= t4; e ^= t0;
    b ^= a; d ^= c; a ^= e; c = ~c;
    s[0] = a ^ rr(a, 19) ^ rr(a, 28);
    s[1] = b ^ rr(b, 61) ^ rr(b, 38);
    s[2] = c ^ rr(c, 1)  ^ rr(c, 6);
    s[3] = d ^ rr(d, 10) ^ rr(d, 17);
    s[4] = e ^ rr(e, 7)  ^ rr(e, 40);
    return s;
  endfunction

  task automatic ref_run(input logic [127:0] d, input logic [11:0] ds, input int n,
                         input logic [127:0] xt, input logic [319:0] st,
                         output logic [319:0] so, output logic [127:0] ro);
    logic [4:0][63:0] s;
    logic [139:0] m;
    logic [9:0] ch;
    for (int i = 0; i < 5; i++) s[i] = il2w(st[64*i +: 32], st[64*i+32 +: 32]);
    m = {ds, d};
    for (int k = 0; k < 14; k++) begin
      ch = m[10*k +: 10];
      for (int i = 0; i < 5; i++)
        s[i] ^= il2w(xt[32*ch[2*i +: 2] +: 32], 32'd0);
      if (k < 13) s = ref_round(s, 8'hf0);
    end
    ro = '0;
    for (int j = 0; j < n; j++) begin
      s = ref_round(s, 8'(8'hf0 - 8'(8'h0f * j)));
      ro[31:0]   ^= w_ev(s[0]) ^ w_od(s[2]);
      ro[63:32]  ^= w_od(s[0]) ^ w_ev(s[3]);
      ro[95:64]  ^= w_ev(s[1]) ^ w_od(s[3]);
      ro[127:96] ^= w_od(s[1]) ^ w_ev(s[2]);
    end
    for (int i = 0; i < 5; i++) so[64*i +: 64] = {w_od(s[i]), w_ev(s[i])};
  endtask

  // driver: push expectation, launch, disturb inputs
  task automatic run_op(input logic [127:0] d, input logic [11:0] ds, input int n,
                        input logic [127:0] xt, input logic [319:0] st, input bit poke);
    exp_t e;
    ref_run(d, ds, n, xt, st, e.st, e.r);
    e.lat = 15 + n;
    @(negedge clk);
    e.t0 = cyc;
    sb_q.push_back(e);
    data_i = d; dsep_i = ds; rounds_i = 4'(n); xtab_i = xt; state_i = st;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R2: later input changes must not matter
    data_i  = {4{$urandom}};
    dsep_i  = 12'($urandom);
    xtab_i  = {4{$urandom}};
    state_i = {10{$urandom}};
    rounds_i = 4'(1 + ($urandom % 12));
    repeat (4) @(negedge clk);
    // R5: accumulator untouched while mixing
    chk(racc_o == last_r, "R5 racc during mix", {192'd0, racc_o}, {192'd0, last_r});
    if (poke) begin
      start_i = 1'b1; // R10: busy start ignored
      @(negedge clk);
      start_i = 1'b0;
    end
    last_r = e.r;
    while (sb_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_hold) begin
        chk(!done_o, "R11 done pulse width", {319'd0, done_o}, 320'd0);
        chk(state_o == hold_st && racc_o == hold_r, "R11 outputs hold", state_o, hold_st);
        chk_hold = 0;
      end
      if (done_o) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R10 unexpected done", 320'd1, 320'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(state_o == e.st, "R3 R4 R6 R7 final state", state_o, e.st);
          chk(racc_o == e.r, "R8 accumulator", {192'd0, racc_o}, {192'd0, e.r});
          chk(cyc - e.t0 == e.lat, "R9 latency", 320'(cyc - e.t0), 320'(e.lat));
          hold_st = state_o;
          hold_r = racc_o;
          chk_hold = 1;
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(done_o == 1'b0, "R1 done at reset", {319'd0, done_o}, 320'd0);
    chk(state_o == '0, "R1 state at reset", state_o, 320'd0);
    chk(racc_o == '0, "R1 racc at reset", {192'd0, racc_o}, 320'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // all zero operands, shortest run
    run_op('0, 12'h000, 1, '0, '0, 0);
    // tag all ones, longest run (R7)
    run_op({4{$urandom}}, 12'hfff, 12, {4{$urandom}}, {10{$urandom}}, 0);
    // tag all zeros
    run_op({4{$urandom}}, 12'h000, 7, {4{$urandom}}, {10{$urandom}}, 0);
    // data all ones, distinct table words (R4 index decode)
    run_op({128{1'b1}}, 12'hfff, 12, {32'h0000_0008, 32'h0000_0004, 32'h0000_0002, 32'h0000_0001}, '0, 0);
    // single tag bit at the top (R3 ordering)
    run_op('0, 12'h800, 2, {32'hdead_beef, 32'h0, 32'h0, 32'h0}, '0, 0);
    for (int i = 0; i < 8; i++)
      run_op({4{$urandom}}, 12'($urandom), 1 + (i % 12), {4{$urandom}}, {10{$urandom}}, i == 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule